// File: doc/BRIEF.md
# Expansion-Bus Snoop-Stall Retry Controller

This controller sits on the processor-bus side of a bridge to a slower expansion bus. It handles processor transactions that target the expansion bus without deferring them. When such a transaction is presented, the controller stalls the snoop phase and raises a request for the expansion bus. A cycle timer bounds how long that request may remain unanswered.

If the grant arrives inside the window, the controller launches the downstream transfer. It keeps the snoop phase stalled for as long as the target needs, then closes the snoop phase cleanly and delivers a normal data response carrying the read data. If the window runs out first, it closes the snoop phase with no hit, answers with a retry and withdraws its request. Nothing about the attempt is kept, so when the processor reissues the transaction, acquisition starts again with a full window.

The window length is the parameter `TIMEOUT_CYC`, counted in clock cycles. About 400 ns corresponds to 50 cycles at 125 MHz.

Top module: `snoop_retry_bridge`

## Requirements
- R1: While `rst_n` is low and after its release, `snoop_stall`, `xb_req`, `xb_start`, `snoop_done` and `resp_valid` are all low, and `resp_kind` is 2'b00.
- R2: A `txn_valid` sampled while idle latches `txn_addr`. From the next cycle, `snoop_stall` and `xb_req` are high.
- R3: A grant (`xb_gnt` high) during any of the first `TIMEOUT_CYC` cycles of acquisition causes a single-cycle `xb_start` in the following cycle, with `xb_addr` equal to the latched address.
- R4: After a grant, `snoop_stall` stays high until the cycle in which `xb_ready` is sampled high. The wait has no time limit, so the acquisition timeout never applies to it.
- R5: The cycle after `xb_ready`, the controller shows a one-cycle response: `snoop_done` and `resp_valid` are high, `snoop_stall` is low, `resp_kind` is 2'b01 (normal data) and `resp_data` equals the `xb_rdata` sampled with `xb_ready`.
- R6: If no grant is seen in `TIMEOUT_CYC` acquisition cycles, `snoop_stall` lasts exactly `TIMEOUT_CYC` cycles. The next cycle then carries `snoop_done`, `resp_valid`, `resp_kind` 2'b10 (retry), `resp_data` zero, and `xb_req` low.
- R7: After each response the controller returns to idle. A reissued transaction gets a fresh full window, so a grant in its last window cycle still succeeds after an earlier retry.
- R8: `txn_valid` while a transaction is in progress is ignored. `xb_addr` keeps the address of the transaction in progress, and no extra response is produced.
- R9: `xb_gnt` while idle has no effect: no `xb_start` and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | Processor transaction to the expansion bus presented |
| txn_addr | input | ADDR_W | Address of that transaction |
| snoop_stall | output | 1 | Holds the snoop phase in stall |
| snoop_done | output | 1 | Snoop phase ends with no hit (one cycle) |
| resp_valid | output | 1 | Response presented (one cycle) |
| resp_kind | output | 2 | 2'b01 normal data, 2'b10 retry, 2'b00 none |
| resp_data | output | DATA_W | Read data for a normal data response |
| xb_req | output | 1 | Expansion bus request |
| xb_gnt | input | 1 | Expansion bus grant |
| xb_start | output | 1 | Downstream transfer launch pulse |
| xb_addr | output | ADDR_W | Address forwarded downstream |
| xb_ready | input | 1 | Downstream target ready, data valid |
| xb_rdata | input | DATA_W | Downstream read data |

## Verification
The bench builds the controller with `TIMEOUT_CYC` = 6 and the default 32-bit address and data widths. The short window makes both edges reachable in a few cycles: a grant in cycle 6 wins and a grant in cycle 7 loses. It also lets a target that takes four windows' worth of cycles show that the downstream stretch never trips the timeout. Retry followed by reissue, a new request arriving while busy, and grants while idle are all driven at this size.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQUIRE,
    ST_DOWNSTREAM,
    ST_RESP_DATA,
    ST_RESP_RETRY
  } srb_state_e;

  localparam logic [1:0] KIND_NONE  = 2'b00;
  localparam logic [1:0] KIND_DATA  = 2'b01;
  localparam logic [1:0] KIND_RETRY = 2'b10;

  // Window ends when the last remaining cycle passes without a grant.
  function automatic logic window_closed(input logic [31:0] left, input logic gnt);
    return (left == 32'd1) && !gnt;
  endfunction

  // Remaining-cycle count after one acquisition cycle.
  function automatic logic [31:0] step_down(input logic [31:0] left);
    return (left == 32'd0) ? 32'd0 : left - 32'd1;
  endfunction
endpackage

// File: rtl/srb_acq_timer.sv
module srb_acq_timer #(
  parameter int TIMEOUT_CYC = 50,
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  input  logic gnt,
  output logic expire
);
  import srb_pkg::*;

  logic [CNT_W-1:0] left_q;
  logic [31:0]      left_ext;
  logic [31:0]      left_nxt;

  assign left_ext = 32'(left_q);
  assign left_nxt = step_down(left_ext);
  assign expire   = run && window_closed(left_ext, gnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= CNT_W'(TIMEOUT_CYC);
    end else if (run && gnt) begin
      left_q <= '0;
    end else if (run) begin
      left_q <= left_nxt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/srb_ctrl_fsm.sv
module srb_ctrl_fsm
  import srb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txn_valid,
  input  logic       gnt,
  input  logic       ready,
  input  logic       expire,
  output srb_state_e state,
  output logic       load,
  output logic       run,
  output logic       start_evt,
  output logic       capture
);
  srb_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    run       = 1'b0;
    start_evt = 1'b0;
    capture   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (txn_valid) begin
          load    = 1'b1;
          state_d = ST_ACQUIRE;
        end
      end
      ST_ACQUIRE: begin
        run = 1'b1;
        if (gnt) begin
          start_evt = 1'b1;
          state_d   = ST_DOWNSTREAM;
        end else if (expire) begin
          state_d = ST_RESP_RETRY;
        end
      end
      ST_DOWNSTREAM: begin
        if (ready) begin
          capture = 1'b1;
          state_d = ST_RESP_DATA;
        end
      end
      ST_RESP_DATA:  state_d = ST_IDLE;
      ST_RESP_RETRY: state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/srb_datapath.sv
module srb_datapath #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              start_evt,
  input  logic              capture,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              start_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= start_evt;
      if (load)    addr_q <= txn_addr;
      if (capture) data_q <= rdata;
    end
  end
endmodule

// File: rtl/snoop_retry_bridge.sv
module snoop_retry_bridge
  import srb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int TIMEOUT_CYC = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_valid,
  input  logic [ADDR_W-1:0] txn_addr,
  output logic              snoop_stall,
  output logic              snoop_done,
  output logic              resp_valid,
  output logic [1:0]        resp_kind,
  output logic [DATA_W-1:0] resp_data,
  output logic              xb_req,
  input  logic              xb_gnt,
  output logic              xb_start,
  output logic [ADDR_W-1:0] xb_addr,
  input  logic              xb_ready,
  input  logic [DATA_W-1:0] xb_rdata
);
  srb_state_e        state;
  logic              load, run, start_evt, capture, expire;
  logic [DATA_W-1:0] data_q;

  // Named internal events for the checker.
  logic in_acquire, in_downstream, busy, timeout_fire, resp_is_data, resp_is_retry;

  srb_ctrl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .gnt(xb_gnt),
    .ready(xb_ready), .expire(expire), .state(state), .load(load),
    .run(run), .start_evt(start_evt), .capture(capture)
  );

  srb_acq_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .run(run), .gnt(xb_gnt),
    .expire(expire)
  );

  srb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(load), .txn_addr(txn_addr),
    .start_evt(start_evt), .capture(capture), .rdata(xb_rdata),
    .addr_q(xb_addr), .data_q(data_q), .start_q(xb_start)
  );

  assign in_acquire    = (state == ST_ACQUIRE);
  assign in_downstream = (state == ST_DOWNSTREAM);
  assign resp_is_data  = (state == ST_RESP_DATA);
  assign resp_is_retry = (state == ST_RESP_RETRY);
  assign busy          = (state != ST_IDLE);
  assign timeout_fire  = expire;

  assign snoop_stall = in_acquire || in_downstream;
  assign xb_req      = in_acquire || in_downstream;
  assign snoop_done  = resp_is_data || resp_is_retry;
  assign resp_valid  = resp_is_data || resp_is_retry;
  assign resp_kind   = resp_is_data ? KIND_DATA : (resp_is_retry ? KIND_RETRY : KIND_NONE);
  assign resp_data   = resp_is_data ? data_q : '0;
endmodule

// File: rtl/snoop_retry_bridge_chk.sv
module snoop_retry_bridge_chk #(
  parameter int ADDR_W      = 32,
  parameter int TIMEOUT_CYC = 50
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snoop_stall,
  input logic              snoop_done,
  input logic              resp_valid,
  input logic [1:0]        resp_kind,
  input logic              xb_req,
  input logic              xb_gnt,
  input logic              xb_start,
  input logic [ADDR_W-1:0] xb_addr,
  input logic              xb_ready,
  input logic              in_acquire,
  input logic              in_downstream,
  input logic              busy,
  input logic              timeout_fire
);
  int unsigned acq_run;

  always_ff @(posedge clk) begin
    if (!rst_n)          acq_run <= 0;
    else if (in_acquire) acq_run <= acq_run + 1;
    else                 acq_run <= 0;
  end

  assert_done_ends_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_done |-> !snoop_stall && resp_valid);

  assert_start_follows_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xb_start |-> $past(xb_gnt) && $past(in_acquire));

  assert_window_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_acquire |-> acq_run < TIMEOUT_CYC);

  assert_timeout_at_window_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_fire |-> acq_run == TIMEOUT_CYC - 1);

  assert_retry_drops_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_kind == 2'b10) |-> !xb_req && $past(in_acquire));

  assert_data_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_kind == 2'b01) |-> $past(in_downstream) && $past(xb_ready));

  assert_no_timeout_downstream_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_downstream && !xb_ready) |=> in_downstream);

  assert_addr_held_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(xb_addr));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !xb_req && !snoop_stall);
endmodule

bind snoop_retry_bridge snoop_retry_bridge_chk #(.ADDR_W(ADDR_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .snoop_stall(snoop_stall), .snoop_done(snoop_done),
  .resp_valid(resp_valid), .resp_kind(resp_kind), .xb_req(xb_req), .xb_gnt(xb_gnt),
  .xb_start(xb_start), .xb_addr(xb_addr), .xb_ready(xb_ready), .in_acquire(in_acquire),
  .in_downstream(in_downstream), .busy(busy), .timeout_fire(timeout_fire)
);

// File: tb/tb_snoop_retry_bridge.sv
module tb_snoop_retry_bridge;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int T  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          txn_valid = 1'b0;
  logic [AW-1:0] txn_addr = '0;
  logic          snoop_stall, snoop_done, resp_valid, xb_req, xb_start;
  logic [1:0]    resp_kind;
  logic [DW-1:0] resp_data;
  logic          xb_gnt = 1'b0;
  logic [AW-1:0] xb_addr;
  logic          xb_ready = 1'b0;
  logic [DW-1:0] xb_rdata = '0;

  always #4 clk = ~clk;

  snoop_retry_bridge #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_CYC(T)) dut (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_addr(txn_addr),
    .snoop_stall(snoop_stall), .snoop_done(snoop_done), .resp_valid(resp_valid),
    .resp_kind(resp_kind), .resp_data(resp_data), .xb_req(xb_req), .xb_gnt(xb_gnt),
    .xb_start(xb_start), .xb_addr(xb_addr), .xb_ready(xb_ready), .xb_rdata(xb_rdata)
  );

  typedef struct packed {
    logic [1:0]    kind;
    logic [DW-1:0] data;
    int            stall;
  } exp_t;

  exp_t          exp_q[$];
  logic [AW-1:0] addr_q[$];
  int checks = 0, fails = 0;
  int stall_run = 0, starts_seen = 0, starts_exp = 0, cycles = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: scoreboard pop on every response.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (snoop_stall) stall_run++;
      if (xb_start) begin
        starts_seen++;
        if (addr_q.size() == 0) chk(1'b0, "R9 unexpected start", 64'(starts_seen), 64'(starts_exp));
        else begin
          logic [AW-1:0] ea;
          ea = addr_q.pop_front();
          chk(xb_addr == ea, "R3 start address", 64'(xb_addr), 64'(ea));
        end
      end
      if (resp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 extra response", 64'(resp_kind), 64'd0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(resp_kind == e.kind, "R5/R6 resp_kind", 64'(resp_kind), 64'(e.kind));
          chk(resp_data == e.data, "R5/R6 resp_data", 64'(resp_data), 64'(e.data));
          chk(stall_run == e.stall, "R4/R6 stall length", 64'(stall_run), 64'(e.stall));
          chk(snoop_done && !snoop_stall, "R5 done without stall", {snoop_done, snoop_stall}, 64'b10);
          if (e.kind == 2'b10) chk(!xb_req, "R6 request withdrawn", 64'(xb_req), 64'd0);
        end
        stall_run = 0;
      end
    end
  end

  // Driver: g = grant cycle in window (0 = never), r = ready cycle downstream.
  task automatic run_txn(input logic [AW-1:0] a, input int g, input int r,
                         input logic [DW-1:0] d, input bit poke);
    exp_t e;
    bit win;
    win = (g >= 1 && g <= T);
    e.kind  = win ? 2'b01 : 2'b10;
    e.data  = win ? d : '0;
    e.stall = win ? g + r : T;
    exp_q.push_back(e);
    if (win) begin
      addr_q.push_back(a);
      starts_exp++;
    end
    txn_valid = 1'b1; txn_addr = a;
    @(negedge clk);
    txn_valid = 1'b0; txn_addr = '0;
    chk(snoop_stall && xb_req, "R2 stall and request raised", {snoop_stall, xb_req}, 64'b11);
    if (win) begin
      for (int i = 1; i <= g; i++) begin
        xb_gnt = (i == g);
        @(negedge clk);
      end
      xb_gnt = 1'b0;
      for (int j = 1; j <= r; j++) begin
        xb_ready = (j == r);
        xb_rdata = (j == r) ? d : ~d;
        if (poke && j == 1) begin txn_valid = 1'b1; txn_addr = ~a; end
        @(negedge clk);
        txn_valid = 1'b0; txn_addr = '0;
      end
      xb_ready = 1'b0; xb_rdata = '0;
      if (poke) chk(xb_addr == a, "R8 busy request ignored", 64'(xb_addr), 64'(a));
    end else begin
      for (int i = 1; i <= T; i++) begin
        xb_gnt = (g > T && i == T) ? 1'b0 : 1'b0;
        @(negedge clk);
      end
      if (g > T) begin
        // late grant lands in the response cycle: must be ignored
        xb_gnt = 1'b1;
      end
    end
    @(negedge clk);
    xb_gnt = 1'b0;
    chk(!snoop_stall && !resp_valid, "R7 back to idle", {snoop_stall, resp_valid}, 64'd0);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!snoop_stall && !xb_req && !xb_start && !snoop_done && !resp_valid && resp_kind == 2'b00,
        "R1 reset outputs", {snoop_stall, xb_req, xb_start, snoop_done, resp_valid, resp_kind}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!snoop_stall && !xb_req && !resp_valid, "R1 after reset", {snoop_stall, xb_req, resp_valid}, 64'd0);

    run_txn(32'h0000_0071, 1, 1, 32'hA5A5_0001, 1'b0);      // R3 R5 quick grant
    run_txn(32'h1234_5678, 3, 2, 32'hDEAD_BEEF, 1'b1);      // R8 poke while busy
    run_txn(32'h0000_0071, 0, 0, 32'h0, 1'b0);             // R6 no grant
    run_txn(32'h0000_0071, T, 1, 32'h0BAD_F00D, 1'b0);      // R7 fresh window, last cycle
    run_txn(32'h0000_0072, T + 1, 0, 32'h0, 1'b0);         // R6 grant one cycle late
    run_txn(32'h0000_0073, 2, 4 * T, 32'hC0FF_EE00, 1'b0);  // R4 slow target

    // R9: grant while idle does nothing
    xb_gnt = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!xb_start && !snoop_stall, "R9 idle grant ignored", {xb_start, snoop_stall}, 64'd0);
    end
    xb_gnt = 1'b0;
    repeat (2) @(negedge clk);

    chk(exp_q.size() == 0, "R5 all responses seen", 64'(exp_q.size()), 64'd0);
    chk(starts_seen == starts_exp, "R3 start count", 64'(starts_seen), 64'(starts_exp));
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule